// File: doc/BRIEF.md
# Exception Entry Unit

This block works out the state a processor moves to when it takes a trap or an interrupt. Each cycle it reads the current program counter, a flag that marks an instruction sitting in a branch delay slot, the Status, Cause and EPC register values, and a flag that a failed translation found no matching entry. In a cycle where the take strobe is high, it registers the handler address, the saved return address, and new Cause and Status words. In any other cycle it registers the incoming values as they are. The caller writes these outputs back into its architectural registers.

The handler address is a base plus an offset. A Status bit picks the base. The offset depends on whether the processor is already inside a handler, on the exception code, on the no-match flag and on a Cause bit that gives interrupts their own entry point. A small helper path reads the 5-bit exception code field in Cause and can overwrite it. The overwritten code is the one that selects the vector in the same cycle.

Top module: `exc_entry_unit`

## Requirements
- R1: `code_rd_o` always equals bits 6:2 of `cause_i`, with no clock delay.
- R2: When `code_wr_en_i` is high, bits 6:2 of the registered Cause take `code_wr_val_i` and every other bit keeps its source value. The written code, not the old one, selects the vector in that same cycle.
- R3: On take with Status bit 1 (EXL) already 1: `epc_o` keeps `epc_i`, Cause bit 31 (BD) keeps its input value, and the offset is 0x180 for every code.
- R4: On take with EXL 0 and `in_dslot_i` low: `epc_o` becomes `pc_i` and BD becomes 0.
- R5: On take with EXL 0 and `in_dslot_i` high: `epc_o` becomes `pc_i` minus 4 and BD becomes 1.
- R6: On take with EXL 0 and code 2 or 3 (translation miss on load or on store): the offset is 0x000 when `tlb_nomatch_i` is 1 and 0x180 when it is 0.
- R7: On take with EXL 0 and code 0 (interrupt): the offset is 0x200 when Cause bit 23 is 1 and 0x180 when it is 0.
- R8: On take with EXL 0, every code other than 0, 2 and 3 uses offset 0x180.
- R9: On take, `pc_o` is the base plus the offset. The base is 0x80000000 when Status bit 22 (BEV) is 0 and 0xBFC00200 when it is 1.
- R10: On take, `status_o` equals `status_i` with bit 1 set, and `dslot_pend_o` is 0.
- R11: With no take, `pc_o`, `epc_o`, `status_o`, `dslot_pend_o` and `cause_o` (after any R2 write) equal the inputs from the cycle before.
- R12: While `rst_n` is low, all registered outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| take_i | input | 1 | Take the exception in this cycle |
| pc_i | input | 32 | Current program counter |
| in_dslot_i | input | 1 | Faulting instruction is in a branch delay slot |
| dslot_pend_i | input | 1 | Current pending delay-slot state |
| status_i | input | 32 | Current Status word |
| cause_i | input | 32 | Current Cause word |
| epc_i | input | 32 | Current EPC |
| tlb_nomatch_i | input | 1 | Translation found no matching entry |
| code_wr_en_i | input | 1 | Overwrite the exception code field |
| code_wr_val_i | input | 5 | New exception code |
| code_rd_o | output | 5 | Exception code field of `cause_i` |
| pc_o | output | 32 | Registered next program counter |
| epc_o | output | 32 | Registered EPC |
| cause_o | output | 32 | Registered Cause |
| status_o | output | 32 | Registered Status |
| dslot_pend_o | output | 1 | Registered pending delay-slot state |

## Verification
The bound checker checks the following on every cycle:
- EXL is set and the delay-slot state is cleared after each take.
- EPC and BD are held when a take arrives with EXL already set.
- EPC holds the PC minus 4 with BD set for a delay-slot fault.
- The top bits of the vector come from the base that BEV selects.
- Outputs pass through when there is no take.

Only the directed scenarios can show the following:
- The exact offset chosen for each combination of code, no-match flag and interrupt-vector bit.
- That a code written in the same cycle steers the vector.
- That the bits of the code field's neighbours survive a write.

// File: rtl/exc_entry_pkg.sv
// Shared constants for the exception entry unit.
// Assumes a 32-bit machine word and the conventional coprocessor-0 bit positions.
package exc_entry_pkg;
    localparam int unsigned XLEN      = 32;
    localparam int unsigned CODE_W    = 5;
    localparam int unsigned CODE_LSB  = 2;
    localparam int unsigned CODE_MSB  = CODE_LSB + CODE_W - 1;
    localparam int unsigned BD_BIT    = 31;
    localparam int unsigned IV_BIT    = 23;
    localparam int unsigned EXL_BIT   = 1;
    localparam int unsigned BEV_BIT   = 22;
    localparam int unsigned INSN_B    = 4;

    localparam logic [CODE_W-1:0] CODE_IRQ  = 5'd0;
    localparam logic [CODE_W-1:0] CODE_TLBL = 5'd2;
    localparam logic [CODE_W-1:0] CODE_TLBS = 5'd3;

    localparam logic [XLEN-1:0] BASE_NORM = 32'h8000_0000;
    localparam logic [XLEN-1:0] BASE_BOOT = 32'hBFC0_0200;
    localparam logic [XLEN-1:0] OFS_REFILL = 32'h0000_0000;
    localparam logic [XLEN-1:0] OFS_GEN    = 32'h0000_0180;
    localparam logic [XLEN-1:0] OFS_IRQ    = 32'h0000_0200;

    typedef enum logic [1:0] {
        VEC_REFILL  = 2'd0,
        VEC_GENERAL = 2'd1,
        VEC_IRQ     = 2'd2
    } vec_kind_e;
endpackage

// File: rtl/exc_code_field.sv
// Reads the exception code field of a Cause word and, when asked, replaces it.
// Assumes the field position given by the package; other bits are kept as they are.
module exc_code_field
    import exc_entry_pkg::*;
(
    input  logic [XLEN-1:0]   cause_i,
    input  logic              wr_en_i,
    input  logic [CODE_W-1:0] wr_val_i,
    output logic [CODE_W-1:0] code_rd_o,
    output logic [XLEN-1:0]   cause_eff_o,
    output logic [CODE_W-1:0] code_eff_o
);
    // Extract the field from the unmodified word.
    assign code_rd_o = cause_i[CODE_MSB:CODE_LSB];

    // Clear the field, then insert the new code when a write is requested.
    always_comb begin
        cause_eff_o = cause_i;
        if (wr_en_i) begin
            cause_eff_o[CODE_MSB:CODE_LSB] = '0;
            cause_eff_o = cause_eff_o | (XLEN'(wr_val_i) << CODE_LSB);
        end
        code_eff_o = cause_eff_o[CODE_MSB:CODE_LSB];
    end
endmodule

// File: rtl/exc_vector_sel.sv
// Picks the handler offset and base, and returns their sum.
// Assumes the code input is already the effective code for this cycle.
module exc_vector_sel
    import exc_entry_pkg::*;
(
    input  logic              exl_i,
    input  logic              bev_i,
    input  logic              iv_i,
    input  logic              nomatch_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [XLEN-1:0]   vector_o
);
    vec_kind_e       kind;
    logic [XLEN-1:0] offset;
    logic [XLEN-1:0] base;

    // Classify the entry: a nested entry always uses the general vector.
    always_comb begin
        kind = VEC_GENERAL;
        if (!exl_i) begin
            if ((code_i == CODE_TLBL) || (code_i == CODE_TLBS)) begin
                kind = nomatch_i ? VEC_REFILL : VEC_GENERAL;
            end else if (code_i == CODE_IRQ) begin
                kind = iv_i ? VEC_IRQ : VEC_GENERAL;
            end
        end
    end

    // Map the class to an offset and add it to the selected base.
    always_comb begin
        case (kind)
            VEC_REFILL: offset = OFS_REFILL;
            VEC_IRQ:    offset = OFS_IRQ;
            default:    offset = OFS_GEN;
        endcase
        base     = bev_i ? BASE_BOOT : BASE_NORM;
        vector_o = base + offset;
    end
endmodule

// File: rtl/exc_epc_calc.sv
// Computes the new return address and branch-delay flag.
// Assumes fixed-size instructions of INSN_B bytes; a nested entry leaves both untouched.
module exc_epc_calc
    import exc_entry_pkg::*;
(
    input  logic            exl_i,
    input  logic            in_dslot_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] epc_i,
    input  logic            bd_i,
    output logic [XLEN-1:0] epc_o,
    output logic            bd_o
);
    // Hold, point at the faulting instruction, or point at the branch before it.
    always_comb begin
        if (exl_i) begin
            epc_o = epc_i;
            bd_o  = bd_i;
        end else if (in_dslot_i) begin
            epc_o = pc_i - XLEN'(INSN_B);
            bd_o  = 1'b1;
        end else begin
            epc_o = pc_i;
            bd_o  = 1'b0;
        end
    end
endmodule

// File: rtl/exc_entry_unit.sv
// Exception entry unit: registers the next PC, EPC, Cause and Status.
// On take it applies the entry rules; otherwise it registers its inputs as they are.
// Assumes the caller writes the outputs back into its architectural registers.
module exc_entry_unit
    import exc_entry_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic              in_dslot_i,
    input  logic              dslot_pend_i,
    input  logic [XLEN-1:0]   status_i,
    input  logic [XLEN-1:0]   cause_i,
    input  logic [XLEN-1:0]   epc_i,
    input  logic              tlb_nomatch_i,
    input  logic              code_wr_en_i,
    input  logic [CODE_W-1:0] code_wr_val_i,
    output logic [CODE_W-1:0] code_rd_o,
    output logic [XLEN-1:0]   pc_o,
    output logic [XLEN-1:0]   epc_o,
    output logic [XLEN-1:0]   cause_o,
    output logic [XLEN-1:0]   status_o,
    output logic              dslot_pend_o
);
    logic [XLEN-1:0]   cause_eff;
    logic [CODE_W-1:0] code_eff;
    logic [XLEN-1:0]   vector;
    logic [XLEN-1:0]   epc_nxt;
    logic              bd_nxt;
    logic [XLEN-1:0]   cause_take;
    logic [XLEN-1:0]   status_take;

    exc_code_field u_code (
        .cause_i     (cause_i),
        .wr_en_i     (code_wr_en_i),
        .wr_val_i    (code_wr_val_i),
        .code_rd_o   (code_rd_o),
        .cause_eff_o (cause_eff),
        .code_eff_o  (code_eff)
    );

    exc_vector_sel u_vec (
        .exl_i     (status_i[EXL_BIT]),
        .bev_i     (status_i[BEV_BIT]),
        .iv_i      (cause_eff[IV_BIT]),
        .nomatch_i (tlb_nomatch_i),
        .code_i    (code_eff),
        .vector_o  (vector)
    );

    exc_epc_calc u_epc (
        .exl_i      (status_i[EXL_BIT]),
        .in_dslot_i (in_dslot_i),
        .pc_i       (pc_i),
        .epc_i      (epc_i),
        .bd_i       (cause_eff[BD_BIT]),
        .epc_o      (epc_nxt),
        .bd_o       (bd_nxt)
    );

    // Form the Cause and Status words written on an entry.
    always_comb begin
        cause_take          = cause_eff;
        cause_take[BD_BIT]  = bd_nxt;
        status_take         = status_i;
        status_take[EXL_BIT] = 1'b1;
    end

    // Register either the entry state or the incoming state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_o         <= '0;
            epc_o        <= '0;
            cause_o      <= '0;
            status_o     <= '0;
            dslot_pend_o <= 1'b0;
        end else if (take_i) begin
            pc_o         <= vector;
            epc_o        <= epc_nxt;
            cause_o      <= cause_take;
            status_o     <= status_take;
            dslot_pend_o <= 1'b0;
        end else begin
            pc_o         <= pc_i;
            epc_o        <= epc_i;
            cause_o      <= cause_eff;
            status_o     <= status_i;
            dslot_pend_o <= dslot_pend_i;
        end
    end
endmodule

// File: rtl/exc_entry_unit_chk.sv
// Property checker for the exception entry unit, attached by bind.
// Assumes the port meanings of the top module; it checks only across clock edges.
module exc_entry_unit_chk
    import exc_entry_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            take_i,
    input logic [XLEN-1:0] pc_i,
    input logic            in_dslot_i,
    input logic            dslot_pend_i,
    input logic [XLEN-1:0] status_i,
    input logic            cause_bd_i,
    input logic [XLEN-1:0] epc_i,
    input logic [XLEN-1:0] pc_o,
    input logic [XLEN-1:0] epc_o,
    input logic            cause_bd_o,
    input logic [XLEN-1:0] status_o,
    input logic            dslot_pend_o
);
    logic live_q;

    // Mark that the previous edge was outside reset, so $past refers to real inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    p_reset_zero_r12: assert property (@(posedge clk)
        $past(!rst_n) |-> (pc_o == '0 && epc_o == '0 && status_o == '0 && !dslot_pend_o));

    p_exl_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(take_i)) |-> (status_o[EXL_BIT] && !dslot_pend_o));

    p_nested_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(take_i) && $past(status_i[EXL_BIT]))
            |-> (epc_o == $past(epc_i) && cause_bd_o == $past(cause_bd_i)));

    p_slot_epc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(take_i) && !$past(status_i[EXL_BIT]) && $past(in_dslot_i))
            |-> (epc_o == $past(pc_i) - 32'd4 && cause_bd_o));

    p_plain_epc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(take_i) && !$past(status_i[EXL_BIT]) && !$past(in_dslot_i))
            |-> (epc_o == $past(pc_i) && !cause_bd_o));

    p_base_norm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(take_i) && !$past(status_i[BEV_BIT]))
            |-> (pc_o[31:12] == 20'h80000));

    p_base_boot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(take_i) && $past(status_i[BEV_BIT]))
            |-> (pc_o[31:12] == 20'hBFC00));

    p_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !$past(take_i))
            |-> (pc_o == $past(pc_i) && epc_o == $past(epc_i)
                 && status_o == $past(status_i) && dslot_pend_o == $past(dslot_pend_i)));
endmodule

bind exc_entry_unit exc_entry_unit_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .take_i       (take_i),
    .pc_i         (pc_i),
    .in_dslot_i   (in_dslot_i),
    .dslot_pend_i (dslot_pend_i),
    .status_i     (status_i),
    .cause_bd_i   (cause_i[31]),
    .epc_i        (epc_i),
    .pc_o         (pc_o),
    .epc_o        (epc_o),
    .cause_bd_o   (cause_o[31]),
    .status_o     (status_o),
    .dslot_pend_o (dslot_pend_o)
);

// File: tb/exc_entry_unit_tb_top.sv
// Directed bench for the exception entry unit: one task per scenario.
module exc_entry_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        take_i = 1'b0;
    logic [31:0] pc_i = '0;
    logic        in_dslot_i = 1'b0;
    logic        dslot_pend_i = 1'b0;
    logic [31:0] status_i = '0;
    logic [31:0] cause_i = '0;
    logic [31:0] epc_i = '0;
    logic        tlb_nomatch_i = 1'b0;
    logic        code_wr_en_i = 1'b0;
    logic [4:0]  code_wr_val_i = '0;
    logic [4:0]  code_rd_o;
    logic [31:0] pc_o, epc_o, cause_o, status_o;
    logic        dslot_pend_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    exc_entry_unit dut_i (
        .clk(clk), .rst_n(rst_n), .take_i(take_i), .pc_i(pc_i),
        .in_dslot_i(in_dslot_i), .dslot_pend_i(dslot_pend_i),
        .status_i(status_i), .cause_i(cause_i), .epc_i(epc_i),
        .tlb_nomatch_i(tlb_nomatch_i), .code_wr_en_i(code_wr_en_i),
        .code_wr_val_i(code_wr_val_i), .code_rd_o(code_rd_o),
        .pc_o(pc_o), .epc_o(epc_o), .cause_o(cause_o),
        .status_o(status_o), .dslot_pend_o(dslot_pend_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Drive one cycle of inputs at the falling edge; results are read one falling edge later.
    task automatic cycle(input logic tk, input logic [31:0] pc, input logic slot,
                         input logic pend, input logic [31:0] st, input logic [31:0] ca,
                         input logic [31:0] ep, input logic nm, input logic we,
                         input logic [4:0] wv);
        @(negedge clk);
        take_i = tk; pc_i = pc; in_dslot_i = slot; dslot_pend_i = pend;
        status_i = st; cause_i = ca; epc_i = ep; tlb_nomatch_i = nm;
        code_wr_en_i = we; code_wr_val_i = wv;
        @(posedge clk);
        @(negedge clk);
        take_i = 1'b0; code_wr_en_i = 1'b0;
    endtask

    task automatic t_reset();
        cause_i = 32'h0000_0050;
        #1;
        chk("R1 code read", {27'd0, code_rd_o}, 32'd20);
        chk("R12 pc", pc_o, 32'h0);
        chk("R12 epc", epc_o, 32'h0);
        chk("R12 cause", cause_o, 32'h0);
        chk("R12 status", status_o, 32'h0);
    endtask

    task automatic t_passthrough();
        cycle(0, 32'h1234_5678, 0, 1, 32'h0000_0010, 32'h0000_0024, 32'hAAAA_0000, 0, 0, 0);
        chk("R1 code read", {27'd0, code_rd_o}, 32'd9);
        chk("R11 pc", pc_o, 32'h1234_5678);
        chk("R11 epc", epc_o, 32'hAAAA_0000);
        chk("R11 cause", cause_o, 32'h0000_0024);
        chk("R11 status", status_o, 32'h0000_0010);
        chk("R11 pend", {31'd0, dslot_pend_o}, 32'd1);
    endtask

    task automatic t_plain_entry();
        cycle(1, 32'h0040_0100, 0, 1, 32'h0000_0010, 32'h8000_0024, 32'h5555_0000, 0, 0, 0);
        chk("R4 epc", epc_o, 32'h0040_0100);
        chk("R4 bd clear", cause_o, 32'h0000_0024);
        chk("R8 R9 pc", pc_o, 32'h8000_0180);
        chk("R10 status", status_o, 32'h0000_0012);
        chk("R10 pend", {31'd0, dslot_pend_o}, 32'd0);
    endtask

    task automatic t_slot_entry();
        cycle(1, 32'h0040_0208, 1, 1, 32'h0040_0000, 32'h0000_0024, 32'h5555_0000, 0, 0, 0);
        chk("R5 epc", epc_o, 32'h0040_0204);
        chk("R5 bd set", cause_o, 32'h8000_0024);
        chk("R9 boot pc", pc_o, 32'hBFC0_0380);
        chk("R10 status", status_o, 32'h0040_0002);
    endtask

    task automatic t_nested();
        cycle(1, 32'h0040_0300, 1, 0, 32'h0000_0002, 32'h8000_0008, 32'h1111_0000, 1, 0, 0);
        chk("R3 epc held", epc_o, 32'h1111_0000);
        chk("R3 bd held", cause_o, 32'h8000_0008);
        chk("R3 pc", pc_o, 32'h8000_0180);
        cycle(1, 32'h0040_0300, 0, 0, 32'h0000_0002, 32'h0000_0008, 32'h2222_0000, 1, 0, 0);
        chk("R3 bd held low", cause_o, 32'h0000_0008);
        chk("R3 epc held", epc_o, 32'h2222_0000);
    endtask

    task automatic t_tlb();
        cycle(1, 32'h0040_0400, 0, 0, 32'h0, 32'h0000_0008, 32'h0, 1, 0, 0);
        chk("R6 load refill", pc_o, 32'h8000_0000);
        cycle(1, 32'h0040_0400, 0, 0, 32'h0, 32'h0000_000C, 32'h0, 0, 0, 0);
        chk("R6 store match", pc_o, 32'h8000_0180);
        cycle(1, 32'h0040_0400, 0, 0, 32'h0040_0000, 32'h0000_000C, 32'h0, 1, 0, 0);
        chk("R6 store refill boot", pc_o, 32'hBFC0_0200);
        cycle(1, 32'h0040_0400, 0, 0, 32'h0, 32'h0000_0004, 32'h0, 1, 0, 0);
        chk("R8 code1 nomatch", pc_o, 32'h8000_0180);
    endtask

    task automatic t_irq();
        cycle(1, 32'h0040_0500, 0, 0, 32'h0, 32'h0080_0000, 32'h0, 0, 0, 0);
        chk("R7 iv set", pc_o, 32'h8000_0200);
        cycle(1, 32'h0040_0500, 0, 0, 32'h0, 32'h0000_0000, 32'h0, 1, 0, 0);
        chk("R7 iv clear", pc_o, 32'h8000_0180);
        cycle(1, 32'h0040_0500, 0, 0, 32'h0040_0000, 32'h0080_0000, 32'h0, 0, 0, 0);
        chk("R7 iv boot", pc_o, 32'hBFC0_0400);
        cycle(1, 32'h0040_0500, 0, 0, 32'h0000_0002, 32'h0080_0000, 32'h0, 0, 0, 0);
        chk("R3 nested irq", pc_o, 32'h8000_0180);
    endtask

    task automatic t_code_write();
        cycle(0, 32'h0, 0, 0, 32'h0, 32'hFFFF_FFFF, 32'h0, 0, 1, 5'd5);
        chk("R2 write keeps others", cause_o, 32'hFFFF_FF97);
        cycle(1, 32'h0040_0600, 0, 0, 32'h0, 32'h0000_0024, 32'h0, 1, 1, 5'd2);
        chk("R2 written code steers", pc_o, 32'h8000_0000);
        chk("R2 cause", cause_o, 32'h0000_0008);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_passthrough();
        t_plain_entry();
        t_slot_entry();
        t_nested();
        t_tlb();
        t_irq();
        t_code_write();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule